// File: doc/BRIEF.md
# Late-Write SRAM Command Sequencer

This block sits on the host side of a pipelined synchronous SRAM that takes write data one cycle after the write command. It accepts read and write requests over a valid/ready handshake and issues one command per clock: deselect, read or write. Write data is delayed inside the block so that it reaches the memory data bus exactly one clock after its command. While it does this, the block enforces the memory's safe-state rules. It inserts deselect cycles before a write that follows a read, it holds off reads during the power-up interval, and it runs complete entry and exit sequences for the sleep pin and for the read-mode pin.

Power-state changes arrive on a separate control handshake. Such a request is accepted only when no data request is pending. The block raises `busy` while a sequence runs. A sleep request first drains the pipeline with deselects and then asserts the sleep pin. A wake request releases the pin and then issues only deselects for a recovery window, which is derived from a picosecond recovery time and the clock period. A mode change drains the pipeline, flips the mode pin and then waits through a settling window of deselects. All counts are parameters.

Top module: `lwsram_cmd_seq`

## Requirements
- R1: A request accepted in one cycle (req_valid and req_ready high at the edge) appears on mem_cmd in the next cycle with its address on mem_addr. mem_cmd is encoded as 2'b00 deselect, 2'b01 read and 2'b10 write. In every other cycle mem_cmd is deselect. A write or a read after a write is accepted with no wait.
- R2: mem_wdata_en is high exactly in the cycle after a write command, and mem_wdata then carries that write's data.
- R3: Between a read command and a later write command there are at least TURN_IDLE (1 or 2) deselect cycles. req_ready stays low for a pending write until that gap is met.
- R4: No read command is issued and req_ready stays low for a pending read until PWRUP_N clock edges have passed since reset. Writes are accepted during this interval.
- R5: ctl_op 2'b01 requests sleep. mem_sleep rises only after at least PRE_IDLE consecutive deselect cycles. While mem_sleep is high, only deselects are issued and requests are refused. busy is high from acceptance until mem_sleep is set.
- R6: ctl_op 2'b10 (accepted only while asleep) releases mem_sleep. At least REC_N = ceil(ZZR_PS/CLK_PS) deselect cycles follow before any read or write. busy is high for exactly REC_N cycles after acceptance.
- R7: ctl_op 2'b11 sets mem_mode to ctl_mode. mem_mode changes only after at least PRE_IDLE consecutive deselects, and at least SETTLE_N deselects follow the change before any read or write. With the bus already idle, a request presented in the cycle after acceptance waits SETTLE_N+2 sampled cycles.
- R8: ctl_ready is high only while req_valid is low. The valid states are: op 2'b01 or 2'b11 while running and awake, and op 2'b10 while asleep. ctl_op 2'b00 is never accepted.
- R9: In reset, mem_cmd is deselect, mem_sleep is low, mem_mode equals MODE_INIT, mem_wdata_en is low and busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Data request present |
| req_ready | output | 1 | Data request taken at this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data of the request |
| ctl_valid | input | 1 | Power/mode request present |
| ctl_ready | output | 1 | Power/mode request taken at this edge |
| ctl_op | input | 2 | 01 sleep, 10 wake, 11 set mode, 00 none |
| ctl_mode | input | 1 | New mode pin value for op 11 |
| busy | output | 1 | Entry, exit or settle sequence in progress |
| mem_cmd | output | 2 | Command to the memory this cycle |
| mem_addr | output | AW | Address with the command |
| mem_wdata | output | DW | Write data bus value |
| mem_wdata_en | output | 1 | Drive mem_wdata this cycle |
| mem_sleep | output | 1 | Sleep pin |
| mem_mode | output | 1 | Read-mode pin |

## Verification
A corrupted idle-run count or last-command flag shows up as a write issued directly after a read, or as sleep or a mode flip with fewer than two quiet cycles before it. The bench's history model flags this in the same cycle. A wrong wait counter moves the end of `busy` and the first command after a wake or mode change, and the expected wait length exposes it at the first request that follows. A lost write-data stage or a wrong power-up count makes the data strobe, the data value or a read ready appear one cycle off. The bench compares these every clock, so such an error is reported in the cycle it first reaches the ports.

// File: rtl/lwseq_pkg.sv
package lwseq_pkg;
    typedef enum logic [1:0] {
        CMD_DES = 2'b00,
        CMD_RD  = 2'b01,
        CMD_WR  = 2'b10
    } cmd_e;

    typedef enum logic [1:0] {
        OP_NONE      = 2'b00,
        OP_SLEEP_IN  = 2'b01,
        OP_SLEEP_OUT = 2'b10,
        OP_MODE      = 2'b11
    } ctl_op_e;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_DRAIN,
        ST_SLEEP,
        ST_RECOV,
        ST_SETTLE
    } seq_st_e;
endpackage

// File: rtl/lwseq_pwr_gate.sv
module lwseq_pwr_gate #(
    parameter int PWRUP_N = 8192
) (
    input  logic clk,
    input  logic rst_n,
    output logic pwr_done
);
    localparam int CW = $clog2(PWRUP_N + 1);
    localparam logic [CW-1:0] LIMIT = CW'(PWRUP_N);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d    = cnt_q;
        pwr_done = (cnt_q == LIMIT);
        if (!pwr_done) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R4: once reads are allowed they stay allowed
    a_r4_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_done |=> pwr_done);
endmodule

// File: rtl/lwseq_idle_track.sv
module lwseq_idle_track
    import lwseq_pkg::*;
#(
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    cmd,
    output logic [IW-1:0] idle_run,
    output logic          last_rd
);
    localparam logic [IW-1:0] RUN_MAX = '1;

    logic [IW-1:0] run_q;
    logic          rd_q;

    always_comb begin
        if (cmd == CMD_DES) idle_run = (run_q == RUN_MAX) ? RUN_MAX : run_q + 1'b1;
        else                idle_run = '0;
        if (cmd == CMD_RD)      last_rd = 1'b1;
        else if (cmd == CMD_WR) last_rd = 1'b0;
        else                    last_rd = rd_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= RUN_MAX;
            rd_q  <= 1'b0;
        end else begin
            run_q <= idle_run;
            rd_q  <= last_rd;
        end
    end

    // R3: a read resets the quiet-cycle run seen in the next cycle
    a_r3_run_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_RD) |=> (cmd != CMD_DES) || (idle_run == IW'(1)));
endmodule

// File: rtl/lwsram_cmd_seq.sv
module lwsram_cmd_seq
    import lwseq_pkg::*;
#(
    parameter int AW        = 19,
    parameter int DW        = 36,
    parameter int PRE_IDLE  = 2,
    parameter int TURN_IDLE = 1,
    parameter int SETTLE_N  = 32,
    parameter int PWRUP_N   = 8192,
    parameter int CLK_PS    = 10000,
    parameter int ZZR_PS    = 20000,
    parameter bit MODE_INIT = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          ctl_valid,
    output logic          ctl_ready,
    input  logic [1:0]    ctl_op,
    input  logic          ctl_mode,
    output logic          busy,
    output logic [1:0]    mem_cmd,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_wdata_en,
    output logic          mem_sleep,
    output logic          mem_mode
);
    localparam int REC_RAW  = (ZZR_PS + CLK_PS - 1) / CLK_PS;
    localparam int REC_N    = (REC_RAW < 1) ? 1 : REC_RAW;
    localparam int WAIT_MAX = (SETTLE_N > REC_N) ? SETTLE_N : REC_N;
    localparam int WW       = $clog2(WAIT_MAX + 1);
    localparam int IDLE_MAX = (PRE_IDLE > TURN_IDLE) ? PRE_IDLE : TURN_IDLE;
    localparam int IW       = $clog2(IDLE_MAX + 1) + 1;
    localparam logic [IW-1:0] PRE_L    = IW'(PRE_IDLE);
    localparam logic [IW-1:0] TURN_L   = IW'(TURN_IDLE);
    localparam logic [WW-1:0] SETTLE_L = WW'(SETTLE_N - 1);
    localparam logic [WW-1:0] REC_L    = WW'(REC_N - 1);

    typedef struct packed {
        seq_st_e       st;
        cmd_e          cmd;
        logic [AW-1:0] addr;
        logic [DW-1:0] pend;
        logic [DW-1:0] wdat;
        logic          wen;
        logic          sleep;
        logic          mode;
        logic          mode_nxt;
        logic          go_sleep;
        logic [WW-1:0] wait_c;
    } seq_s;

    seq_s          cur_q, nxt_d;
    logic [IW-1:0] idle_run;
    logic          last_rd;
    logic          pwr_done;

    lwseq_pwr_gate #(.PWRUP_N(PWRUP_N)) u_pwr (
        .clk(clk), .rst_n(rst_n), .pwr_done(pwr_done)
    );

    lwseq_idle_track #(.IW(IW)) u_idle (
        .clk(clk), .rst_n(rst_n), .cmd(cur_q.cmd),
        .idle_run(idle_run), .last_rd(last_rd)
    );

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.cmd  = CMD_DES;
        nxt_d.wen  = (cur_q.cmd == CMD_WR);
        nxt_d.wdat = cur_q.pend;
        req_ready  = 1'b0;
        ctl_ready  = 1'b0;
        case (cur_q.st)
            ST_RUN: begin
                req_ready = req_write ? (!last_rd || idle_run >= TURN_L) : pwr_done;
                if (req_valid) begin
                    if (req_ready) begin
                        nxt_d.cmd  = req_write ? CMD_WR : CMD_RD;
                        nxt_d.addr = req_addr;
                        nxt_d.pend = req_wdata;
                    end
                end else begin
                    ctl_ready = (ctl_op == OP_SLEEP_IN) || (ctl_op == OP_MODE);
                    if (ctl_valid && ctl_ready) begin
                        nxt_d.st       = ST_DRAIN;
                        nxt_d.go_sleep = (ctl_op == OP_SLEEP_IN);
                        nxt_d.mode_nxt = ctl_mode;
                    end
                end
            end
            ST_DRAIN: begin
                if (idle_run >= PRE_L) begin
                    if (cur_q.go_sleep) begin
                        nxt_d.sleep = 1'b1;
                        nxt_d.st    = ST_SLEEP;
                    end else begin
                        nxt_d.mode   = cur_q.mode_nxt;
                        nxt_d.st     = ST_SETTLE;
                        nxt_d.wait_c = SETTLE_L;
                    end
                end
            end
            ST_SLEEP: begin
                if (!req_valid) begin
                    ctl_ready = (ctl_op == OP_SLEEP_OUT);
                    if (ctl_valid && ctl_ready) begin
                        nxt_d.sleep  = 1'b0;
                        nxt_d.st     = ST_RECOV;
                        nxt_d.wait_c = REC_L;
                    end
                end
            end
            ST_RECOV, ST_SETTLE: begin
                if (cur_q.wait_c == '0) nxt_d.st = ST_RUN;
                else                    nxt_d.wait_c = cur_q.wait_c - 1'b1;
            end
            default: nxt_d.st = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.st       <= ST_RUN;
            cur_q.cmd      <= CMD_DES;
            cur_q.addr     <= '0;
            cur_q.pend     <= '0;
            cur_q.wdat     <= '0;
            cur_q.wen      <= 1'b0;
            cur_q.sleep    <= 1'b0;
            cur_q.mode     <= MODE_INIT;
            cur_q.mode_nxt <= MODE_INIT;
            cur_q.go_sleep <= 1'b0;
            cur_q.wait_c   <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign mem_cmd      = cur_q.cmd;
    assign mem_addr     = cur_q.addr;
    assign mem_wdata    = cur_q.wdat;
    assign mem_wdata_en = cur_q.wen;
    assign mem_sleep    = cur_q.sleep;
    assign mem_mode     = cur_q.mode;
    assign busy         = (cur_q.st == ST_DRAIN) || (cur_q.st == ST_RECOV) ||
                          (cur_q.st == ST_SETTLE);

    // Window counters used only by the assertions below
    localparam int CKW = $clog2(WAIT_MAX + 2);
    localparam logic [CKW-1:0] CK_SAT = '1;
    logic [CKW-1:0] wake_cnt_q, mode_cnt_q;
    logic           mode_prev_q;
    logic           is_des;
    assign is_des = (mem_cmd == CMD_DES);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wake_cnt_q  <= CK_SAT;
            mode_cnt_q  <= CK_SAT;
            mode_prev_q <= MODE_INIT;
        end else begin
            mode_prev_q <= mem_mode;
            if (mem_sleep)                         wake_cnt_q <= '0;
            else if (is_des && wake_cnt_q != CK_SAT) wake_cnt_q <= wake_cnt_q + 1'b1;
            if (mem_mode != mode_prev_q)           mode_cnt_q <= CKW'(is_des);
            else if (is_des && mode_cnt_q != CK_SAT) mode_cnt_q <= mode_cnt_q + 1'b1;
        end
    end

    a_r1_accept_issues: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !is_des);
    a_r2_data_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cmd == CMD_WR) |=> mem_wdata_en);
    a_r2_data_only_after_wr: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wdata_en |-> ($past(mem_cmd) == CMD_WR));
    a_r3_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cmd == CMD_WR) |-> ($past(mem_cmd) != CMD_RD));
    generate
        if (TURN_IDLE >= 2) begin : g_turn2
            a_r3_turnaround2: assert property (@(posedge clk) disable iff (!rst_n)
                (mem_cmd == CMD_WR) |-> ($past(mem_cmd, 2) != CMD_RD));
        end
    endgenerate
    a_r4_no_early_read: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cmd == CMD_RD) |-> pwr_done);
    a_r5_sleep_drained: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_sleep) |-> ($past(is_des) && $past(is_des, 2)));
    a_r5_quiet_asleep: assert property (@(posedge clk) disable iff (!rst_n)
        mem_sleep |-> is_des);
    a_r6_wake_window: assert property (@(posedge clk) disable iff (!rst_n)
        !is_des |-> (wake_cnt_q >= CKW'(REC_N)));
    a_r7_mode_drained: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_mode != mode_prev_q) |-> ($past(is_des) && $past(is_des, 2)));
    a_r7_mode_settle: assert property (@(posedge clk) disable iff (!rst_n)
        !is_des |-> (mode_cnt_q >= CKW'(SETTLE_N)));
    a_r8_ctl_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_valid && ctl_ready) |-> !req_valid);
endmodule

// File: tb/tb_lwsram_cmd_seq.sv
module tb_lwsram_cmd_seq;
    localparam int AW     = 8;
    localparam int DW     = 16;
    localparam int PRE    = 2;
    localparam int TURN   = 1;
    localparam int SETTLE = 32;
    localparam int PWRUP  = 8192;
    localparam int CLKPS  = 10000;
    localparam int ZZRPS  = 45000;
    localparam int RECN   = (ZZRPS + CLKPS - 1) / CLKPS;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, ctl_valid = 1'b0, ctl_mode = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [1:0] ctl_op = 2'b00;
    logic req_ready, ctl_ready, busy, mem_wdata_en, mem_sleep, mem_mode;
    logic [1:0] mem_cmd;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;

    always #5 clk = ~clk;

    lwsram_cmd_seq #(.AW(AW), .DW(DW), .PRE_IDLE(PRE), .TURN_IDLE(TURN),
        .SETTLE_N(SETTLE), .PWRUP_N(PWRUP), .CLK_PS(CLKPS), .ZZR_PS(ZZRPS),
        .MODE_INIT(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .ctl_valid(ctl_valid), .ctl_ready(ctl_ready), .ctl_op(ctl_op),
        .ctl_mode(ctl_mode), .busy(busy), .mem_cmd(mem_cmd), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_wdata_en(mem_wdata_en),
        .mem_sleep(mem_sleep), .mem_mode(mem_mode));

    int checks = 0, bad = 0;
    bit done = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural reference: history of presented commands and handshakes
    int edges = 0;
    always @(posedge clk) if (rst_n) edges++;

    bit p_fire = 0, p_w = 0, p_wr_cmd = 0, last_rd = 0, p_sleep = 0, p_mode = 1;
    logic [AW-1:0] p_addr = '0;
    logic [DW-1:0] p_data = '0, d_next = '0;
    int des_run = 1000, wake_des = 1000, mode_des = 1000;

    always @(negedge clk) begin
        logic [1:0] exp_cmd;
        if (rst_n && !done) begin
            exp_cmd = p_fire ? (p_w ? 2'b10 : 2'b01) : 2'b00;
            check(mem_cmd == exp_cmd, "R1 command", mem_cmd, exp_cmd);
            if (p_fire) check(mem_addr == p_addr, "R1 address", mem_addr, p_addr);
            check(mem_wdata_en == p_wr_cmd, "R2 data strobe", mem_wdata_en, p_wr_cmd);
            if (p_wr_cmd) check(mem_wdata == d_next, "R2 data value", mem_wdata, d_next);
            if (mem_cmd == 2'b10 && last_rd)
                check(des_run >= TURN, "R3 read-to-write gap", des_run, TURN);
            if (mem_cmd == 2'b01) check(edges > PWRUP, "R4 early read", edges, PWRUP + 1);
            if (req_valid && !req_write && edges < PWRUP)
                check(!req_ready, "R4 read held", req_ready, 0);
            if (mem_sleep && !p_sleep) check(des_run >= PRE, "R5 drain before sleep", des_run, PRE);
            if (mem_sleep) check(mem_cmd == 2'b00, "R5 quiet while asleep", mem_cmd, 0);
            if (mem_sleep) check(!req_ready, "R5 refuse while asleep", req_ready, 0);
            if (mem_cmd != 2'b00) check(wake_des >= RECN, "R6 recovery window", wake_des, RECN);
            if (mem_mode != p_mode) check(des_run >= PRE, "R7 drain before mode", des_run, PRE);
            if (mem_cmd != 2'b00) check(mode_des >= SETTLE, "R7 settle window", mode_des, SETTLE);
            if (ctl_ready) check(!req_valid && ctl_op != 2'b00, "R8 control gating", ctl_op, 1);
            if (mem_mode != p_mode) mode_des = (mem_cmd == 2'b00) ? 1 : 0;
            else if (mem_cmd == 2'b00) mode_des++;
            if (mem_sleep) wake_des = 0;
            else if (mem_cmd == 2'b00) wake_des++;
            des_run = (mem_cmd == 2'b00) ? des_run + 1 : 0;
            if (mem_cmd == 2'b01) last_rd = 1;
            else if (mem_cmd == 2'b10) last_rd = 0;
            d_next   = p_data;
            p_wr_cmd = (mem_cmd == 2'b10);
            p_fire   = req_valid && req_ready;
            p_w      = req_write;
            p_addr   = req_addr;
            p_data   = req_wdata;
            p_sleep  = mem_sleep;
            p_mode   = mem_mode;
        end
    end

    task automatic do_req(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          output int waits);
        req_valid = 1; req_write = w; req_addr = a; req_wdata = d; waits = 0;
        do begin @(negedge clk); waits++; end while (!req_ready);
        @(posedge clk); #1;
        req_valid = 0;
    endtask

    task automatic do_ctl(input logic [1:0] op, input logic m);
        ctl_valid = 1; ctl_op = op; ctl_mode = m;
        do @(negedge clk); while (!ctl_ready);
        @(posedge clk); #1;
        ctl_valid = 0; ctl_op = 2'b00;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        int w, n;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(mem_cmd == 2'b00, "R9 reset command", mem_cmd, 0);
        check(mem_sleep == 0, "R9 reset sleep", mem_sleep, 0);
        check(mem_mode == 1, "R9 reset mode", mem_mode, 1);
        check(busy == 0, "R9 reset busy", busy, 0);
        check(mem_wdata_en == 0, "R9 reset strobe", mem_wdata_en, 0);
        @(posedge clk); #1;
        rst_n = 1;

        // Writes during power-up, back to back
        do_req(1, 8'h10, 16'hA5A5, w); check(w == 1, "R4 write allowed early", w, 1);
        do_req(1, 8'h11, 16'h5A5A, w); check(w == 1, "R1 write after write", w, 1);
        do_req(1, 8'h12, 16'h1234, w); check(w == 1, "R1 write after write", w, 1);
        // First read stalls until the power-up interval has passed
        do_req(0, 8'h10, 16'h0, w);
        check(w > 8000, "R4 read stalled", w, PWRUP);
        // Read then write: turnaround
        do_req(0, 8'h11, 16'h0, w); check(w == 1, "R1 read after read", w, 1);
        do_req(1, 8'h20, 16'hBEEF, w); check(w == TURN + 1, "R3 write held after read", w, TURN + 1);
        do_req(0, 8'h21, 16'h0, w); check(w == 1, "R1 read after write", w, 1);
        idle(2);
        do_req(1, 8'h22, 16'h0F0F, w); check(w == 1, "R3 no hold after gap", w, 1);

        // Control refused while a request is pending, bad op refused
        req_valid = 1; req_write = 1; req_addr = 8'h30; req_wdata = 16'hC0DE;
        ctl_valid = 1; ctl_op = 2'b01;
        @(negedge clk);
        check(ctl_ready == 0, "R8 ctl blocked by request", ctl_ready, 0);
        @(posedge clk); #1;
        req_valid = 0; ctl_op = 2'b00;
        @(negedge clk);
        check(ctl_ready == 0, "R8 op none refused", ctl_ready, 0);
        @(posedge clk); #1;
        ctl_op = 2'b10;
        @(negedge clk);
        check(ctl_ready == 0, "R8 wake refused while awake", ctl_ready, 0);
        @(posedge clk); #1;
        ctl_valid = 0; ctl_op = 2'b00;

        // Sleep right after a write
        do_req(1, 8'h31, 16'h7777, w);
        do_ctl(2'b01, 1'b0);
        @(negedge clk);
        check(busy == 1, "R5 busy during drain", busy, 1);
        for (int i = 0; i < 20 && !mem_sleep; i++) @(negedge clk);
        check(mem_sleep == 1, "R5 sleep asserted", mem_sleep, 1);
        check(busy == 0, "R5 busy clear asleep", busy, 0);
        @(posedge clk); #1;
        req_valid = 1; req_write = 0; req_addr = 8'h12;
        repeat (3) begin
            @(negedge clk);
            check(req_ready == 0, "R5 request refused asleep", req_ready, 0);
        end
        @(posedge clk); #1;
        req_valid = 0;
        do_ctl(2'b10, 1'b0);
        n = 0;
        @(negedge clk);
        check(mem_sleep == 0, "R6 sleep released", mem_sleep, 0);
        while (busy && n < 100) begin n++; @(negedge clk); end
        check(n == RECN, "R6 recovery busy length", n, RECN);
        @(posedge clk); #1;
        do_req(0, 8'h12, 16'h0, w); check(w == 1, "R6 read after recovery", w, 1);

        // Mode change with an idle bus, request waits through settling
        idle(3);
        do_ctl(2'b11, 1'b0);
        do_req(0, 8'h10, 16'h0, w);
        check(w == SETTLE + 2, "R7 request held through settle", w, SETTLE + 2);
        check(mem_mode == 0, "R7 mode changed", mem_mode, 0);
        // Mode change straight after a read
        do_ctl(2'b11, 1'b1);
        n = 0;
        @(negedge clk);
        while (busy && n < 100) begin n++; @(negedge clk); end
        check(mem_mode == 1, "R7 mode restored", mem_mode, 1);
        check(n >= SETTLE + PRE, "R7 sequence length", n, SETTLE + PRE);
        @(posedge clk); #1;
        do_req(1, 8'h40, 16'h4242, w);
        do_req(0, 8'h40, 16'h0, w);
        idle(4);

        done = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule